// File: doc/BRIEF.md
# Programmable-Priority Interrupt Vector Arbiter

This block gathers level-sensitive interrupt requests from a set of peripheral sources and, on every clock where no vector is outstanding, selects one to hand to the processor core. Each peripheral source has a two-bit programmable precedence level. The winner is the source with the highest level. Ties within a level go to the source with the lowest vector number. Two non-maskable lines, a boot reset request and a watchdog reset request, occupy fixed vector slots 0 and 1 and beat every peripheral.

The core supplies its current mask level. A peripheral request is forwarded only when its level is strictly above that mask. The granted vector number and its fetch address are registered and presented with a valid flag. They stay frozen until the core pulses acknowledge. The fetch address is a relocatable table base plus twice the vector number, so each table slot is two 16-bit words. The base and the per-source levels are written through a synchronous address/data/write-enable port.

Top module: `irq_vector_arbiter`

## Requirements
- R1: While `boot_req` is high and no vector is outstanding, the next grant is vector 0, whatever the mask and the other requests are.
- R2: While `wdog_req` is high, `boot_req` is low and no vector is outstanding, the next grant is vector 1, whatever the mask and the peripheral requests are.
- R3: Peripheral source i (bit i of `irq_req`) has vector number i+2. It is a candidate only when its level is strictly greater than `core_mask`. With no candidate, `irq_valid` stays low.
- R4: Among candidates, a source at a higher level always wins over a source at a lower level.
- R5: Among candidates at the same level, the lowest vector number wins.
- R6: `irq_addr` equals the base register plus twice `irq_vector`, modulo 2^ADDR_W.
- R7: After reset, `irq_valid` is low, the base is 0 and every level is 0. A level-0 source therefore never qualifies.
- R8: Once `irq_valid` is high, it stays high and `irq_vector` and `irq_addr` stay unchanged until a cycle with `irq_ack` high. New requests, including non-maskable ones, do not disturb a pending grant.
- R9: A cycle with `irq_valid` and `irq_ack` both high makes `irq_valid` low after that edge. At the following edge, arbitration runs on the requests then present, so a source still asserted is granted again.
- R10: A write with `cfg_addr` 0 loads the base from `cfg_wdata`. A write with `cfg_addr` k, for 1 ≤ k ≤ NUM_SRC, loads the level of source k-1 from `cfg_wdata[1:0]`. Other addresses change nothing. A write applies to the arbitration decision of the clock after the write edge, not to the decision of the write edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_req | input | 1 | Non-maskable boot reset request (vector 0) |
| wdog_req | input | 1 | Non-maskable watchdog reset request (vector 1) |
| irq_req | input | NUM_SRC | Level-sensitive peripheral requests |
| core_mask | input | 2 | Core's current mask level |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | CFG_AW | Configuration register select |
| cfg_wdata | input | ADDR_W | Configuration write data |
| irq_valid | output | 1 | A granted vector is presented |
| irq_vector | output | VEC_W | Granted vector number |
| irq_addr | output | ADDR_W | Vector fetch address |
| irq_ack | input | 1 | Core acknowledge pulse |

## Verification
The bench offers request mixes that separate the two tiers of arbitration. Sources at different levels are mixed so that the lower-numbered source must lose (R4). Sources at equal levels are mixed so that only the index decides (R5). Sets lying wholly at or below the mask check that nothing is granted (R3). Non-maskable lines are raised alongside peripheral requests, and also while a grant is pending. This separates the priority of the fixed slots from the hold rule. Base values near the top of the address range expose a missing wrap, and a write issued in the same cycle as a request shows whether the new level is applied one decision too early.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int LVL_W       = 2;
    localparam int BOOT_VEC    = 0;
    localparam int WDOG_VEC    = 1;
    localparam int PERIPH_VEC0 = 2;

    typedef logic [LVL_W-1:0] level_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 16,
    parameter int CFG_AW  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [CFG_AW-1:0]          addr,
    input  logic [ADDR_W-1:0]          wdata,
    output logic [NUM_SRC-1:0][LVL_W-1:0] lvl_o,
    output logic [ADDR_W-1:0]          base_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
        logic [ADDR_W-1:0]             base;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (addr == '0) begin
                st_d.base = wdata;
            end
            for (int k = 0; k < NUM_SRC; k++) begin
                if (addr == CFG_AW'(k + 1)) begin
                    st_d.lvl[k] = wdata[LVL_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o  = st_q.lvl;
    assign base_o = st_q.base;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 4
) (
    input  logic                          boot,
    input  logic                          wdog,
    input  logic [NUM_SRC-1:0]            req,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0]              mask,
    output logic                          hit,
    output logic [VEC_W-1:0]              vec
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0] qual;
    logic               periph_hit;
    level_t             best_lvl;
    logic [IDX_W-1:0]   best_idx;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_qual
        assign qual[g] = req[g] && (lvl[g] > mask);
    end

    // Scan from the top index down; ">=" lets a lower index take a tie.
    always_comb begin
        periph_hit = 1'b0;
        best_lvl   = '0;
        best_idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (qual[i] && (!periph_hit || lvl[i] >= best_lvl)) begin
                periph_hit = 1'b1;
                best_lvl   = lvl[i];
                best_idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        hit = boot || wdog || periph_hit;
        if (boot) begin
            vec = VEC_W'(BOOT_VEC);
        end else if (wdog) begin
            vec = VEC_W'(WDOG_VEC);
        end else begin
            vec = VEC_W'(PERIPH_VEC0) + VEC_W'(best_idx);
        end
    end
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int ADDR_W  = 16,
    localparam int CFG_AW = $clog2(NUM_SRC + 1),
    localparam int VEC_W  = $clog2(NUM_SRC + PERIPH_VEC0)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               boot_req,
    input  logic               wdog_req,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [LVL_W-1:0]   core_mask,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    output logic               irq_valid,
    output logic [VEC_W-1:0]   irq_vector,
    output logic [ADDR_W-1:0]  irq_addr,
    input  logic               irq_ack
);
    typedef struct packed {
        logic              valid;
        logic [VEC_W-1:0]  vec;
        logic [ADDR_W-1:0] addr;
    } grant_t;

    logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
    logic [ADDR_W-1:0]             base;
    logic                          pick_hit;
    logic [VEC_W-1:0]              pick_vec;
    grant_t                        gr_d, gr_q;

    irq_cfg_regs #(
        .NUM_SRC(NUM_SRC),
        .ADDR_W (ADDR_W),
        .CFG_AW (CFG_AW)
    ) i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .lvl_o (lvl),
        .base_o(base)
    );

    irq_prio_pick #(
        .NUM_SRC(NUM_SRC),
        .VEC_W  (VEC_W)
    ) i_pick (
        .boot(boot_req),
        .wdog(wdog_req),
        .req (irq_req),
        .lvl (lvl),
        .mask(core_mask),
        .hit (pick_hit),
        .vec (pick_vec)
    );

    always_comb begin
        gr_d = gr_q;
        if (gr_q.valid) begin
            if (irq_ack) begin
                gr_d.valid = 1'b0;
            end
        end else if (pick_hit) begin
            gr_d.valid = 1'b1;
            gr_d.vec   = pick_vec;
            gr_d.addr  = base + (ADDR_W'(pick_vec) << 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gr_q <= '0;
        end else begin
            gr_q <= gr_d;
        end
    end

    assign irq_valid  = gr_q.valid;
    assign irq_vector = gr_q.vec;
    assign irq_addr   = gr_q.addr;

    a_r1_boot_first: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_req && !irq_valid) |=> (irq_valid && irq_vector == VEC_W'(BOOT_VEC)));

    a_r2_wdog_next: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_req && !boot_req && !irq_valid) |=> (irq_valid && irq_vector == VEC_W'(WDOG_VEC)));

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !irq_ack) |=> (irq_valid && $stable(irq_vector) && $stable(irq_addr)));

    a_r9_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ack) |=> !irq_valid);
endmodule

// File: tb/test_irq_vector_arbiter.sv
module test_irq_vector_arbiter;
    localparam int NS = 8;
    localparam int AW = 16;
    localparam int CW = 4;
    localparam int VW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          boot_req = 1'b0, wdog_req = 1'b0;
    logic [NS-1:0] irq_req = '0;
    logic [1:0]    core_mask = '0;
    logic          cfg_we = 1'b0;
    logic [CW-1:0] cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          irq_valid;
    logic [VW-1:0] irq_vector;
    logic [AW-1:0] irq_addr;
    logic          irq_ack = 1'b0;

    int n_tests = 0, n_fail = 0;
    string cur_req = "R7";
    bit finished = 0;

    always #2 clk = ~clk;

    irq_vector_arbiter #(.NUM_SRC(NS), .ADDR_W(AW)) i_irq_vector_arbiter (
        .clk(clk), .rst_n(rst_n), .boot_req(boot_req), .wdog_req(wdog_req),
        .irq_req(irq_req), .core_mask(core_mask), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq_valid(irq_valid),
        .irq_vector(irq_vector), .irq_addr(irq_addr), .irq_ack(irq_ack)
    );

    // Behavioural reference model
    int m_lvl[NS];
    int m_base;
    bit m_valid;
    int m_vec, m_addr;

    function automatic int model_pick();
        if (boot_req) return 0;
        if (wdog_req) return 1;
        for (int l = 3; l >= 1; l--) begin
            if (l > int'(core_mask)) begin
                for (int s = 0; s < NS; s++)
                    if (irq_req[s] && m_lvl[s] == l) return s + 2;
            end
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_lvl[k]) m_lvl[k] = 0;
            m_base = 0; m_valid = 0; m_vec = 0; m_addr = 0;
        end else begin
            if (m_valid) begin
                if (irq_ack) m_valid = 0;
            end else begin
                int p;
                p = model_pick();
                if (p >= 0) begin
                    m_valid = 1; m_vec = p;
                    m_addr = (m_base + 2 * p) % (1 << AW);
                end
            end
            if (cfg_we) begin
                if (cfg_addr == 0) m_base = int'(cfg_wdata);
                else if (int'(cfg_addr) <= NS) m_lvl[int'(cfg_addr) - 1] = int'(cfg_wdata[1:0]);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_tests++;
            if (irq_valid !== m_valid ||
                (m_valid && (int'(irq_vector) != m_vec || int'(irq_addr) != m_addr))) begin
                n_fail++;
                $display("FAIL %s model: valid=%0b vec=%0d addr=%h expected valid=%0b vec=%0d addr=%h",
                         cur_req, irq_valid, irq_vector, irq_addr, m_valid, m_vec, m_addr[AW-1:0]);
            end
        end
    end

    task automatic chk(string r, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        cfg_we = 1'b1; cfg_addr = CW'(a); cfg_wdata = AW'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_valid();
        for (int c = 0; c < 50; c++) begin
            if (irq_valid) break;
            @(negedge clk);
        end
    endtask

    task automatic serve(output int v, output int a);
        wait_valid();
        v = irq_valid ? int'(irq_vector) : -1;
        a = int'(irq_addr);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        int v, a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 valid after reset", int'(irq_valid), 0);

        cur_req = "R7";
        irq_req[3] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 level-0 source ignored", int'(irq_valid), 0);
        irq_req = '0;

        cur_req = "R10";
        wr(4, 2); wr(6, 2); wr(2, 1); wr(8, 3);

        cur_req = "R4";
        irq_req = 8'b1000_1010;
        serve(v, a); chk("R4 level 3 beats lower", v, 9);
        irq_req[7] = 1'b0;
        serve(v, a); chk("R4 level 2 beats level 1", v, 5);
        irq_req[3] = 1'b0;
        serve(v, a); chk("R4 lone level 1", v, 3);
        irq_req = '0;

        cur_req = "R5";
        irq_req = 8'b0010_1000;
        serve(v, a); chk("R5 lowest index in tie", v, 5);
        irq_req[3] = 1'b0;
        serve(v, a); chk("R5 remaining peer", v, 7);
        irq_req = '0;

        cur_req = "R3";
        core_mask = 2'd2;
        irq_req = 8'b0010_1010;
        repeat (3) @(negedge clk);
        chk("R3 all at or below mask", int'(irq_valid), 0);
        irq_req[7] = 1'b1;
        serve(v, a); chk("R3 above mask passes", v, 9);
        irq_req = '0; core_mask = 2'd0;

        cur_req = "R1";
        core_mask = 2'd3;
        irq_req[7] = 1'b1; wdog_req = 1'b1; boot_req = 1'b1;
        serve(v, a); chk("R1 boot outranks all", v, 0);
        boot_req = 1'b0;
        cur_req = "R2";
        serve(v, a); chk("R2 watchdog next, ignores mask", v, 1);
        wdog_req = 1'b0; core_mask = 2'd0;
        serve(v, a); chk("R2 peripheral after fixed slots", v, 9);
        irq_req = '0;

        cur_req = "R6";
        wr(0, 16'h0100);
        irq_req[3] = 1'b1;
        serve(v, a); chk("R6 base plus twice vector", a, 16'h010A);
        irq_req = '0;
        wr(0, 16'hFFFE);
        irq_req[1] = 1'b1;
        serve(v, a); chk("R6 address wraps", a, 16'h0004);
        irq_req = '0;
        wr(0, 0);

        cur_req = "R8";
        irq_req[1] = 1'b1;
        wait_valid();
        boot_req = 1'b1; irq_req[7] = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R8 grant held", int'(irq_vector), 3);
        end
        serve(v, a); chk("R8 held vector acked", v, 3);
        serve(v, a); chk("R8 boot after release", v, 0);
        boot_req = 1'b0;
        serve(v, a); chk("R8 next peripheral", v, 9);
        irq_req = '0;

        cur_req = "R9";
        irq_req[3] = 1'b1;
        serve(v, a); chk("R9 first grant", v, 5);
        chk("R9 valid low after ack", int'(irq_valid), 0);
        @(negedge clk);
        chk("R9 still-asserted source regranted", int'(irq_vector), 5);
        chk("R9 valid back", int'(irq_valid), 1);
        serve(v, a);
        irq_req = '0;

        cur_req = "R10";
        irq_req[2] = 1'b1;
        wr(3, 3);
        chk("R10 write not yet applied", int'(irq_valid), 0);
        @(negedge clk);
        chk("R10 write applied next decision", int'(irq_vector), 4);
        serve(v, a);
        irq_req = '0;
        wr(12, 3);
        irq_req[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 out-of-range write ignored", int'(irq_valid), 0);
        irq_req = '0;
        repeat (2) @(negedge clk);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule